// File: doc/BRIEF.md
# Two-Slot Valid/Stop Elastic Buffer

This block sits between two pipeline stages and decouples them with two storage slots. Each side uses a forward valid and a backward stop handshake. A word moves across a channel in any cycle where valid is high and stop is low. No central stall controller is needed, because every buffer absorbs a one-cycle stall of its consumer on its own. Words leave in the order they arrived, and the oldest held word is always the one presented downstream.

The block also classifies the downstream channel every cycle. A cycle is idle when valid is low, a transfer when valid is high and stop is low, and a retry when both are high. The classification of the cycle that has just ended is held in a register and driven on an output, so other logic can watch the protocol without decoding the handshake itself.

Top module: `elastic_buf2`

## Requirements
- R1: A word on `up_data` is taken into the buffer in a cycle where `up_valid` is 1 and `up_stop` is 0.
- R2: `dn_valid` is 1 exactly when at least one slot holds a word, and `dn_data` is the oldest held word. Words leave in the order they arrived.
- R3: `up_stop` is 1 only when both slots hold a word, so a single-cycle downstream stall never blocks the upstream side.
- R4: After a retry cycle on the downstream channel, `dn_valid` stays 1 and `dn_data` is unchanged in the next cycle.
- R5: When downstream is stalled and one slot is occupied, an incoming word goes into the other slot and the word being presented stays unchanged.
- R6: `chan_state` shows the class of the previous downstream cycle, with 0 for idle (valid low, whatever stop is), 1 for transfer and 2 for retry.
- R7: After a cycle in which `chan_state` is 2 (retry), the next value of `chan_state` is never 0 (idle).
- R8: A synchronous active-high `rst` empties both slots and resets both indices. After reset, `dn_valid` and `up_stop` are 0 and `chan_state` is 0.
- R9: With one word held, a cycle that both accepts and delivers a word keeps one word held, which sustains one word per cycle.
- R10: A word offered while `up_stop` is 1 is ignored. It never appears downstream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| up_valid | input | 1 | Upstream word present |
| up_data | input | DATA_W | Upstream word |
| up_stop | output | 1 | Backpressure to upstream; 1 when both slots are full |
| dn_valid | output | 1 | Downstream word present |
| dn_data | output | DATA_W | Oldest held word |
| dn_stop | input | 1 | Backpressure from downstream |
| chan_state | output | 2 | Class of previous downstream cycle: 0 idle, 1 transfer, 2 retry |

## Verification
The handshake is exercised with a free-flowing stream, with a stall that lasts one cycle while one word is held, with a stall that fills both slots and then retries, and with a stop held high while the output is empty. These patterns separate a buffer that merely passes words from one that keeps the presented word unchanged, from one that asserts upstream stop too early, and from one whose monitor mistakes an empty cycle with stop high for a retry. A dedicated pass offers a distinctive word while the buffer is full and then drains it, which shows whether that word was wrongly captured. A reset applied in the middle of traffic confirms that held words are discarded.

// File: rtl/eb2_pkg.sv
package eb2_pkg;

    localparam int SLOTS = 2;
    localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;

    typedef enum logic [1:0] {
        CH_IDLE  = 2'd0,
        CH_XFER  = 2'd1,
        CH_RETRY = 2'd2
    } ch_state_e;

    typedef struct packed {
        logic push;
        logic pop;
    } hs_t;

    function automatic ch_state_e classify(input logic v, input logic s);
        if (!v)
            return CH_IDLE;
        return s ? CH_RETRY : CH_XFER;
    endfunction

    function automatic logic [IDX_W-1:0] idx_next(input logic [IDX_W-1:0] i);
        if (i == IDX_W'(SLOTS - 1))
            return '0;
        return i + IDX_W'(1);
    endfunction

endpackage

// File: rtl/eb2_index.sv
module eb2_index
    import eb2_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  hs_t              hs,
    output logic [IDX_W-1:0] wr_idx,
    output logic [IDX_W-1:0] rd_idx
);

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_idx <= '0;
            rd_idx <= '0;
        end else begin
            if (hs.push)
                wr_idx <= idx_next(wr_idx);
            if (hs.pop)
                rd_idx <= idx_next(rd_idx);
        end
    end

endmodule

// File: rtl/eb2_slots.sv
module eb2_slots
    import eb2_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  hs_t               hs,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [SLOTS-1:0]  occ,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] slot_q [SLOTS];

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(g);
        logic wr_here;
        logic rd_here;
        assign wr_here = hs.push && (wr_idx == MY_IDX);
        assign rd_here = hs.pop  && (rd_idx == MY_IDX);

        always_ff @(posedge clk) begin
            if (rst) begin
                slot_q[g] <= '0;
                occ[g]    <= 1'b0;
            end else begin
                if (wr_here)
                    slot_q[g] <= wdata;
                if (wr_here)
                    occ[g] <= 1'b1;
                else if (rd_here)
                    occ[g] <= 1'b0;
            end
        end
    end

    assign rdata = slot_q[rd_idx];

endmodule

// File: rtl/eb2_chan_mon.sv
module eb2_chan_mon
    import eb2_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      valid,
    input  logic      stop,
    output ch_state_e state
);

    always_ff @(posedge clk) begin
        if (rst)
            state <= CH_IDLE;
        else
            state <= classify(valid, stop);
    end

endmodule

// File: rtl/elastic_buf2.sv
module elastic_buf2
    import eb2_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              up_valid,
    input  logic [DATA_W-1:0] up_data,
    output logic              up_stop,
    output logic              dn_valid,
    output logic [DATA_W-1:0] dn_data,
    input  logic              dn_stop,
    output logic [1:0]        chan_state
);

    hs_t              hs;
    logic [IDX_W-1:0] wr_idx;
    logic [IDX_W-1:0] rd_idx;
    logic [SLOTS-1:0] occ;
    ch_state_e        mon_state;

    // backpressure depends only on held state, never on dn_stop
    assign up_stop  = &occ;
    assign dn_valid = |occ;
    assign hs.push  = up_valid && !up_stop;
    assign hs.pop   = dn_valid && !dn_stop;

    eb2_index u_idx (
        .clk    (clk),
        .rst    (rst),
        .hs     (hs),
        .wr_idx (wr_idx),
        .rd_idx (rd_idx)
    );

    eb2_slots #(.DATA_W(DATA_W)) u_slots (
        .clk    (clk),
        .rst    (rst),
        .hs     (hs),
        .wr_idx (wr_idx),
        .rd_idx (rd_idx),
        .wdata  (up_data),
        .occ    (occ),
        .rdata  (dn_data)
    );

    eb2_chan_mon u_mon (
        .clk   (clk),
        .rst   (rst),
        .valid (dn_valid),
        .stop  (dn_stop),
        .state (mon_state)
    );

    assign chan_state = mon_state;

endmodule

// File: rtl/eb2_checker.sv
module eb2_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              up_valid,
    input logic              up_stop,
    input logic              dn_valid,
    input logic [DATA_W-1:0] dn_data,
    input logic              dn_stop,
    input logic [1:0]        chan_state
);

    logic [1:0] held;

    always_ff @(posedge clk) begin
        if (rst)
            held <= 2'd0;
        else
            held <= held + {1'b0, (up_valid && !up_stop)} - {1'b0, (dn_valid && !dn_stop)};
    end

    always_comb begin
        if (!rst)
            a_r1_no_overflow: assert (held <= 2'd2);
    end

    a_r2_valid_tracks_fill: assert property (@(posedge clk) disable iff (rst)
        dn_valid == (held != 2'd0));

    a_r3_stop_only_full: assert property (@(posedge clk) disable iff (rst)
        up_stop == (held == 2'd2));

    a_r4_retry_hold: assert property (@(posedge clk) disable iff (rst)
        (dn_valid && dn_stop) |=> (dn_valid && $stable(dn_data)));

    a_r6_xfer_seen: assert property (@(posedge clk) disable iff (rst)
        (dn_valid && !dn_stop) |=> (chan_state == 2'd1));

    a_r7_no_idle_after_retry: assert property (@(posedge clk) disable iff (rst)
        (chan_state == 2'd2) |=> (chan_state != 2'd0));

    a_r8_reset_clears: assert property (@(posedge clk)
        rst |=> (!dn_valid && !up_stop && chan_state == 2'd0));

endmodule

bind elastic_buf2 eb2_checker #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .up_valid   (up_valid),
    .up_stop    (up_stop),
    .dn_valid   (dn_valid),
    .dn_data    (dn_data),
    .dn_stop    (dn_stop),
    .chan_state (chan_state)
);

// File: tb/sim_elastic_buf2.sv
module sim_elastic_buf2;

    localparam int CLK_T = 10;
    localparam int W     = 8;
    localparam int NV    = 14;

    // {up_valid, up_data, dn_stop, exp_dn_valid, exp_dn_data, exp_up_stop, exp_state}
    localparam logic [21:0] VEC [NV] = '{
        {1'b1, 8'hA1, 1'b0, 1'b0, 8'h00, 1'b0, 2'd0},  // R1 first push
        {1'b1, 8'hA2, 1'b0, 1'b1, 8'hA1, 1'b0, 2'd0},  // R9 push+pop
        {1'b1, 8'hA3, 1'b1, 1'b1, 8'hA2, 1'b0, 2'd1},  // R5 stall with one held
        {1'b1, 8'hA4, 1'b1, 1'b1, 8'hA2, 1'b1, 2'd2},  // R4 R10 full, A4 ignored
        {1'b1, 8'hA4, 1'b0, 1'b1, 8'hA2, 1'b1, 2'd2},  // R7 retry then transfer
        {1'b1, 8'hA4, 1'b0, 1'b1, 8'hA3, 1'b0, 2'd1},  // R2 order
        {1'b0, 8'h00, 1'b0, 1'b1, 8'hA4, 1'b0, 2'd1},
        {1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 2'd1},  // R6 empty with stop
        {1'b1, 8'hB1, 1'b1, 1'b0, 8'h00, 1'b0, 2'd0},  // R6 idle despite stop
        {1'b1, 8'hB2, 1'b1, 1'b1, 8'hB1, 1'b0, 2'd0},  // R3 stop low under stall
        {1'b0, 8'h00, 1'b0, 1'b1, 8'hB1, 1'b1, 2'd2},
        {1'b0, 8'h00, 1'b0, 1'b1, 8'hB2, 1'b0, 2'd1},
        {1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 2'd1},
        {1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 2'd0}
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         up_valid = 1'b0;
    logic [W-1:0] up_data = '0;
    logic         up_stop;
    logic         dn_valid;
    logic [W-1:0] dn_data;
    logic         dn_stop = 1'b0;
    logic [1:0]   chan_state;

    int checks = 0;
    int bad    = 0;
    bit done   = 1'b0;

    always #(CLK_T/2) clk = ~clk;

    elastic_buf2 #(.DATA_W(W)) u0 (
        .clk        (clk),
        .rst        (rst),
        .up_valid   (up_valid),
        .up_data    (up_data),
        .up_stop    (up_stop),
        .dn_valid   (dn_valid),
        .dn_data    (dn_data),
        .dn_stop    (dn_stop),
        .chan_state (chan_state)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [W-1:0] d, input logic s);
        @(negedge clk);
        up_valid = v;
        up_data  = d;
        dn_stop  = s;
        #1;
    endtask

    initial begin
        repeat (2) @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R8 dn_valid after reset", {7'd0, dn_valid}, 8'd0);
        chk("R8 up_stop after reset", {7'd0, up_stop}, 8'd0);
        chk("R8 chan_state after reset", {6'd0, chan_state}, 8'd0);

        for (int k = 0; k < NV; k++) begin
            logic [21:0] v;
            v = VEC[k];
            drive(v[21], v[20:13], v[12]);
            chk($sformatf("R2 dn_valid step %0d", k), {7'd0, dn_valid}, {7'd0, v[11]});
            if (v[11])
                chk($sformatf("R2 R5 dn_data step %0d", k), dn_data, v[10:3]);
            chk($sformatf("R3 up_stop step %0d", k), {7'd0, up_stop}, {7'd0, v[2]});
            chk($sformatf("R6 R7 chan_state step %0d", k), {6'd0, chan_state}, {6'd0, v[1:0]});
        end

        // R10: fill, offer a distinct word while stopped, then drain
        drive(1'b1, 8'hC1, 1'b1);
        drive(1'b1, 8'hC2, 1'b1);
        drive(1'b1, 8'hC9, 1'b1);
        chk("R10 up_stop while full", {7'd0, up_stop}, 8'd1);
        drive(1'b0, 8'h00, 1'b0);
        chk("R10 first drained", dn_data, 8'hC1);
        drive(1'b0, 8'h00, 1'b0);
        chk("R10 second drained", dn_data, 8'hC2);
        drive(1'b0, 8'h00, 1'b0);
        chk("R10 offered word not stored", {7'd0, dn_valid}, 8'd0);

        // R8: reset in the middle of traffic
        drive(1'b1, 8'hD1, 1'b1);
        drive(1'b1, 8'hD2, 1'b1);
        drive(1'b0, 8'h00, 1'b1);
        chk("R8 full before reset", {7'd0, up_stop}, 8'd1);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R8 dn_valid cleared", {7'd0, dn_valid}, 8'd0);
        chk("R8 up_stop cleared", {7'd0, up_stop}, 8'd0);
        chk("R8 chan_state idle", {6'd0, chan_state}, 8'd0);
        drive(1'b1, 8'hE1, 1'b0);
        drive(1'b0, 8'h00, 1'b0);
        chk("R1 R8 accepts after reset", dn_data, 8'hE1);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        #(CLK_T * 200000);
        if (!done) begin
            checks++;
            bad++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

endmodule